// File: doc/BRIEF.md
# Dual-Bridge Parallel Rectifier PWM Modulator

This block drives two single-phase full bridges that share one AC source and one DC link. For each bridge it produces one gate signal per leg, four gates in total. Every clock it reads three signed voltage demands: the differential demand for bridge A, the differential demand for bridge B, and a circulating-voltage correction that applies to bridge B only. It also reads a fractional placement factor `mu` and the half-span of the DC link. From these it builds a common offset that can sit anywhere between the lowest and the highest value that keeps all four leg references inside the link span. It adds the offset to the four leg references. It then compares each reference with a triangular carrier made by an up/down counter.

The placement factor sets where the active pulses fall inside each carrier half-period. At zero the offset is at its lower limit, so one leg stays low for the whole period. At one the offset is at its upper limit, so one leg stays high. Halfway, the pulses are centred. A mode pin chooses whether bridge B shares bridge A's carrier or uses a second carrier that runs 180 degrees out of phase. References are captured only at the carrier's peak and valley. This way a change in the demands can never cut a pulse short in the middle of a ramp.

Top module: `par_rect_pwm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four gates are low after that edge. The carrier counter restarts from zero on the rising slope.
- R2: The counter `k` moves by one step on every clock edge. It rises from 0 to 2^CW−1 and then falls back to 0, for a period of 2·(2^CW−1) edges. The leading carrier value is k − (2^(CW−1) − 1).
- R3: The offset is xlo + floor(m·(xhi − xlo)/2^MUW). Here m is `mu` saturated to 2^MUW. xlo is −`dc_half` minus the smallest offset-free leg term. xhi is `dc_half` minus the largest offset-free leg term.
- R4: With `mu` = 0, the lowest leg reference equals −`dc_half`. When `dc_half` = 2^(CW−1), that leg's gate stays low for a full carrier period.
- R5: With `mu` = 2^MUW, the highest leg reference equals `dc_half`. When `dc_half` = 2^(CW−1), that leg's gate stays high for a full carrier period.
- R6: With `mu` = 2^(MUW−1), the offset is the floored midpoint of xlo and xhi.
- R7: The offset-free leg terms are computed with h_a = `va_ref` shifted right arithmetically by one, and h_b formed the same way from `vb_ref`. They are: `qa1` +h_a, `qa2` −h_a, `qb1` h_b − `vo_ref`, `qb2` −h_b − `vo_ref`.
- R8: After a clock edge, a gate is high exactly when its held reference is greater than or equal to the carrier value that applied to its leg just before that edge.
- R9: Leg references are captured only on edges where the counter is at 0 or at 2^CW−1. Changes to the inputs at any other time have no effect on the gates until the next such edge.
- R10: With `mode` = 0, all four legs use the leading carrier. With `mode` = 1, the bridge-B legs use the lagging carrier (2^CW−1−k) − (2^(CW−1) − 1), which runs 180 degrees out of phase with the leading one.
- R11: A `mu` value above 2^MUW acts exactly as 2^MUW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 0: shared carrier, 1: bridge B on lagging carrier |
| mu | input | MUW+1 | Offset placement factor, 2^MUW means one |
| dc_half | input | DW | Half of the DC-link span, signed, positive |
| va_ref | input | DW | Bridge A differential demand, signed |
| vb_ref | input | DW | Bridge B differential demand, signed |
| vo_ref | input | DW | Circulating-voltage correction, signed |
| qa1 | output | 1 | Gate, bridge A leg 1 |
| qa2 | output | 1 | Gate, bridge A leg 2 |
| qb1 | output | 1 | Gate, bridge B leg 1 |
| qb2 | output | 1 | Gate, bridge B leg 2 |

## Verification
The assertions assume that `dc_half` is positive and that the three demands are small enough for every intermediate sum to fit in DW+4 signed bits. The floor and ceiling checks for R4 and R5 rely on this, because they compare the held extreme reference with −`dc_half` and +`dc_half` exactly. The stimulus keeps the demands within a few tens of counts against a 10-bit width. It holds `dc_half` at the carrier half-span. It still includes one overmodulated setting, where xhi falls below xlo, so that a negative offset span and its flooring are also covered. The inputs change only at the falling edge, and mostly between carrier periods. The one exception is a deliberate change in the middle of a ramp, used to test capture at the turning points.

// File: rtl/par_rect_pwm_pkg.sv
package par_rect_pwm_pkg;
   localparam int LEGS    = 4;
   localparam int LEG_QA1 = 0;
   localparam int LEG_QA2 = 1;
   localparam int LEG_QB1 = 2;
   localparam int LEG_QB2 = 3;
   // legs at or above this index belong to bridge B
   localparam int FIRST_B_LEG = LEG_QB1;
endpackage

// File: rtl/par_rect_carrier.sv
module par_rect_carrier #(
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [CW-1:0]        cnt,
   output logic                 turn,
   output logic signed [CW:0]   car_lead,
   output logic signed [CW:0]   car_lag
);
   localparam logic [CW-1:0]      TOP = {CW{1'b1}};
   localparam logic signed [CW:0] OFS = (CW+1)'((1 << (CW-1)) - 1);

   logic rising;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         rising <= 1'b1;
      end else if (rising) begin
         if (cnt == TOP) begin
            rising <= 1'b0;
            cnt    <= cnt - 1'b1;
         end else begin
            cnt    <= cnt + 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            rising <= 1'b1;
            cnt    <= cnt + 1'b1;
         end else begin
            cnt    <= cnt - 1'b1;
         end
      end
   end

   assign turn     = (cnt == '0) || (cnt == TOP);
   // complementing the count mirrors the triangle: half a period of shift
   assign car_lead = $signed({1'b0, cnt})  - OFS;
   assign car_lag  = $signed({1'b0, ~cnt}) - OFS;
endmodule

// File: rtl/par_rect_offset.sv
module par_rect_offset #(
   parameter int DW  = 16,
   parameter int MUW = 8,
   parameter int WW  = DW + 4
) (
   input  logic signed [DW-1:0] va,
   input  logic signed [DW-1:0] vb,
   input  logic signed [DW-1:0] vo,
   input  logic signed [DW-1:0] dch,
   input  logic [MUW:0]         mu,
   output logic signed [WW-1:0] pole [4]
);
   localparam logic [MUW:0] ONE = {1'b1, {MUW{1'b0}}};
   localparam int           PW  = WW + MUW + 2;

   logic signed [WW-1:0] va_w, vb_w, vo_w, dc_w;
   logic signed [WW-1:0] ha, hb, mn, mx, xlo, xhi, span, vx;
   logic signed [WW-1:0] term [4];
   logic [MUW:0]         mu_sat;
   logic signed [PW-1:0] prod, scaled;

   assign va_w = {{(WW-DW){va[DW-1]}}, va};
   assign vb_w = {{(WW-DW){vb[DW-1]}}, vb};
   assign vo_w = {{(WW-DW){vo[DW-1]}}, vo};
   assign dc_w = {{(WW-DW){dch[DW-1]}}, dch};

   assign ha = va_w >>> 1;
   assign hb = vb_w >>> 1;

   assign term[0] =  ha;
   assign term[1] = -ha;
   assign term[2] =  hb - vo_w;
   assign term[3] = -hb - vo_w;

   always_comb begin
      mn = term[0];
      mx = term[0];
      for (int i = 1; i < 4; i++) begin
         if (term[i] < mn) mn = term[i];
         if (term[i] > mx) mx = term[i];
      end
   end

   assign xlo    = -dc_w - mn;
   assign xhi    =  dc_w - mx;
   assign span   = xhi - xlo;
   assign mu_sat = (mu > ONE) ? ONE : mu;
   assign prod   = span * $signed({1'b0, mu_sat});
   assign scaled = prod >>> MUW;
   assign vx     = xlo + scaled[WW-1:0];

   for (genvar g = 0; g < 4; g++) begin : g_pole
      assign pole[g] = term[g] + vx;
   end
endmodule

// File: rtl/par_rect_leg.sv
module par_rect_leg #(
   parameter int WW = 20,
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic signed [WW-1:0] ref_in,
   input  logic signed [CW:0]   car,
   output logic                 q,
   output logic signed [WW-1:0] held
);
   logic signed [WW-1:0] car_w, ref_nx;

   assign car_w  = {{(WW-CW-1){car[CW]}}, car};
   assign ref_nx = load ? ref_in : held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
         q    <= 1'b0;
      end else begin
         held <= ref_nx;
         q    <= (ref_nx >= car_w);
      end
   end
endmodule

// File: rtl/par_rect_pwm.sv
module par_rect_pwm
   import par_rect_pwm_pkg::*;
#(
   parameter int DW  = 16,
   parameter int MUW = 8,
   parameter int CW  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode,
   input  logic [MUW:0]         mu,
   input  logic signed [DW-1:0] dc_half,
   input  logic signed [DW-1:0] va_ref,
   input  logic signed [DW-1:0] vb_ref,
   input  logic signed [DW-1:0] vo_ref,
   output logic                 qa1,
   output logic                 qa2,
   output logic                 qb1,
   output logic                 qb2
);
   localparam int WW = DW + 4;

   if (CW < 2) begin : g_bad_cw
      $error("carrier width must be at least 2");
   end
   if (CW + 2 > WW) begin : g_bad_fit
      $error("carrier does not fit the reference width");
   end
   if (MUW < 1) begin : g_bad_muw
      $error("mu needs at least one fraction bit");
   end

   logic [CW-1:0]        cnt;
   logic                 turn;
   logic signed [CW:0]   car1, car2;
   logic signed [WW-1:0] pole [LEGS];
   logic signed [WW-1:0] held [LEGS];
   logic [LEGS-1:0]      gate;

   par_rect_carrier #(.CW(CW)) u_car (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .turn(turn),
      .car_lead(car1), .car_lag(car2)
   );

   par_rect_offset #(.DW(DW), .MUW(MUW), .WW(WW)) u_ofs (
      .va(va_ref), .vb(vb_ref), .vo(vo_ref), .dch(dc_half),
      .mu(mu), .pole(pole)
   );

   for (genvar g = 0; g < LEGS; g++) begin : g_leg
      logic signed [CW:0] car_sel;
      if (g < FIRST_B_LEG) begin : g_a
         assign car_sel = car1;
      end else begin : g_b
         assign car_sel = mode ? car2 : car1;
      end
      par_rect_leg #(.WW(WW), .CW(CW)) u_leg (
         .clk(clk), .rst_n(rst_n), .load(turn), .ref_in(pole[g]),
         .car(car_sel), .q(gate[g]), .held(held[g])
      );
   end

   assign qa1 = gate[LEG_QA1];
   assign qa2 = gate[LEG_QA2];
   assign qb1 = gate[LEG_QB1];
   assign qb2 = gate[LEG_QB2];
endmodule

// File: rtl/par_rect_pwm_chk.sv
module par_rect_pwm_chk #(
   parameter int DW  = 16,
   parameter int MUW = 8,
   parameter int CW  = 16,
   parameter int WW  = DW + 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [MUW:0]         mu,
   input logic signed [DW-1:0] dc_half,
   input logic                 qa1,
   input logic                 qa2,
   input logic                 qb1,
   input logic                 qb2,
   input logic [CW-1:0]        cnt,
   input logic                 turn,
   input logic signed [WW-1:0] held [4]
);
   localparam logic [MUW:0] ONE = {1'b1, {MUW{1'b0}}};

   logic signed [WW-1:0] lo, hi, dc_w;

   assign dc_w = {{(WW-DW){dc_half[DW-1]}}, dc_half};

   always_comb begin
      lo = held[0];
      hi = held[0];
      for (int i = 1; i < 4; i++) begin
         if (held[i] < lo) lo = held[i];
         if (held[i] > hi) hi = held[i];
      end
   end

   assert_reset_low_R1: assert property (@(posedge clk)
      !rst_n |=> ({qa1, qa2, qb1, qb2} == 4'b0000));

   assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
                 ({1'b0, $past(cnt)} == {1'b0, cnt} + 1'b1)));

   assert_hold_between_turns_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !turn) |=> ($stable(held[0]) && $stable(held[1]) &&
                            $stable(held[2]) && $stable(held[3])));

   assert_floor_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && turn && mu == '0) |=> (lo == -$past(dc_w)));

   assert_ceiling_at_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && turn && mu >= ONE) |=> (hi == $past(dc_w))); // also R11
endmodule

bind par_rect_pwm par_rect_pwm_chk #(.DW(DW), .MUW(MUW), .CW(CW), .WW(WW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mu(mu), .dc_half(dc_half),
   .qa1(qa1), .qa2(qa2), .qb1(qb1), .qb2(qb2),
   .cnt(cnt), .turn(turn), .held(held)
);

// File: tb/par_rect_pwm_bench.sv
module par_rect_pwm_bench;
   localparam int DW  = 10;
   localparam int MUW = 4;
   localparam int CW  = 5;
   localparam int TOPV = (1 << CW) - 1;
   localparam int HS   = 1 << (CW - 1);
   localparam int ONE  = 1 << MUW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b0;
   logic [MUW:0] mu = '0;
   logic signed [DW-1:0] dc_half = 10'(HS);
   logic signed [DW-1:0] va = '0, vb = '0, vo = '0;
   logic qa1, qa2, qb1, qb2;

   int n_chk = 0, n_bad = 0;
   int m_cnt = 0;
   bit m_up = 1'b1;
   int m_lat [4] = '{0, 0, 0, 0};
   string tag = "R1";
   bit acc_on = 1'b0;
   bit acc_or [4];
   bit acc_and [4];
   int hi_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   par_rect_pwm #(.DW(DW), .MUW(MUW), .CW(CW)) u_par_rect_pwm (
      .clk(clk), .rst_n(rst_n), .mode(mode), .mu(mu), .dc_half(dc_half),
      .va_ref(va), .vb_ref(vb), .vo_ref(vo),
      .qa1(qa1), .qa2(qa2), .qb1(qb1), .qb2(qb2)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   task automatic capture();
      int ha, hb, mn, mx, xlo, xhi, mue, vx;
      int t [4];
      ha = int'(va) >>> 1;
      hb = int'(vb) >>> 1;
      t[0] = ha; t[1] = -ha; t[2] = hb - int'(vo); t[3] = -hb - int'(vo);
      mn = t[0]; mx = t[0];
      for (int i = 1; i < 4; i++) begin
         if (t[i] < mn) mn = t[i];
         if (t[i] > mx) mx = t[i];
      end
      xlo = -int'(dc_half) - mn;
      xhi =  int'(dc_half) - mx;
      mue = (int'(mu) > ONE) ? ONE : int'(mu);
      vx  = xlo + ((mue * (xhi - xlo)) >>> MUW);
      for (int i = 0; i < 4; i++) m_lat[i] = t[i] + vx;
   endtask

   task automatic tick();
      int e [4];
      logic [3:0] gv;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin e[i] = 0; m_lat[i] = 0; end
         m_cnt = 0; m_up = 1'b1;
      end else begin
         if (m_cnt == 0 || m_cnt == TOPV) capture();
         for (int i = 0; i < 4; i++) begin
            int c;
            c = (mode && i >= 2) ? (TOPV - m_cnt) - (HS - 1) : m_cnt - (HS - 1);
            e[i] = (m_lat[i] >= c) ? 1 : 0;
         end
         if (m_up) begin
            if (m_cnt == TOPV) begin m_up = 1'b0; m_cnt = TOPV - 1; end
            else m_cnt++;
         end else begin
            if (m_cnt == 0) begin m_up = 1'b1; m_cnt = 1; end
            else m_cnt--;
         end
      end
      @(posedge clk);
      @(negedge clk);
      gv = {qb2, qb1, qa2, qa1};
      for (int i = 0; i < 4; i++) begin
         chk(int'(gv[i]) == e[i], $sformatf("%s leg%0d", tag, i), int'(gv[i]), e[i]);
         if (acc_on) begin
            acc_or[i]  = acc_or[i] | gv[i];
            acc_and[i] = acc_and[i] & gv[i];
         end
      end
      if (acc_on && gv[0]) hi_cnt++;
   endtask

   // settle one half period, then observe one full period
   task automatic run_period();
      for (int i = 0; i < TOPV; i++) tick();
      for (int i = 0; i < 4; i++) begin acc_or[i] = 1'b0; acc_and[i] = 1'b1; end
      hi_cnt = 0;
      acc_on = 1'b1;
      for (int i = 0; i < 2 * TOPV; i++) tick();
      acc_on = 1'b0;
   endtask

   initial begin
      int vecs [4][3] = '{'{0, 0, 0}, '{12, -8, 2}, '{-21, 17, -3}, '{30, 30, 5}};
      bit found;
      @(negedge clk);
      tag = "R1 reset";
      for (int i = 0; i < 4; i++) tick();
      rst_n = 1'b1;

      // R2: centred zero demand gives high on counts 0..HS-1
      tag = "R2 R8";
      mu = 5'(ONE / 2);
      run_period();
      chk(hi_cnt == 2 * HS - 1, "R2 duty", hi_cnt, 2 * HS - 1);

      for (int md = 0; md < 2; md++) begin
         for (int v = 0; v < 4; v++) begin
            for (int m = 0; m <= ONE + 2; m++) begin
               mode = md[0];
               va = 10'(vecs[v][0]); vb = 10'(vecs[v][1]); vo = 10'(vecs[v][2]);
               mu = 5'(m);
               if (m == 0)             tag = "R4 R3 R7 R8 R10";
               else if (m == ONE)      tag = "R5 R3 R7 R8 R10";
               else if (m == ONE / 2)  tag = "R6 R3 R7 R8 R10";
               else if (m > ONE)       tag = "R11 R7 R8 R10";
               else                    tag = "R3 R7 R8 R10";
               run_period();
               if (m == 0) begin
                  found = 1'b0;
                  for (int i = 0; i < 4; i++) if (!acc_or[i]) found = 1'b1;
                  chk(found, "R4 clamped-low leg", int'(found), 1);
               end
               if (m >= ONE) begin
                  found = 1'b0;
                  for (int i = 0; i < 4; i++) if (acc_and[i]) found = 1'b1;
                  chk(found, "R5 R11 clamped-high leg", int'(found), 1);
               end
            end
         end
      end

      // R9: change demand in the middle of a ramp
      tag = "R9 capture";
      mode = 1'b0; va = 10'sd12; vb = -10'sd8; vo = 10'sd2; mu = 5'd5;
      for (int i = 0; i < 2 * TOPV + TOPV / 2; i++) tick();
      va = -10'sd40; vo = 10'sd9; mu = 5'd13;
      for (int i = 0; i < 2 * TOPV; i++) tick();

      // R1: reset in the middle of a period, then restart
      tag = "R1 mid-run reset";
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) tick();
      rst_n = 1'b1;
      tag = "R1 R2 restart";
      for (int i = 0; i < 2 * TOPV; i++) tick();

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule